// File: doc/BRIEF.md
# Subtract-with-Borrow Execute Unit

This block carries out a single register-file subtract-with-borrow instruction for a small 8-bit core built around one accumulator. It takes W, subtracts an operand read from the register file, and also subtracts a borrow. The borrow is the complement of the carry flag. The result goes either to W or back to the register it was read from, and five condition flags are updated with it.

An instruction word is accepted when it is offered and the unit is ready. The unit then runs four fixed phases, one clock each:
- Phase 1 decodes the word and forms the 12-bit data address.
- Phase 2 issues a read on the register-file port.
- Phase 3 computes the result and the flags.
- Phase 4 drives the write to the register file when the file is the destination.

W and the flags change on the edge that ends phase 4. A new instruction can be accepted on that same edge, so a stream of instructions runs at one per four clocks. W and the flags can be preloaded while the unit is idle. This stands in for the other instructions of the core, which are outside this block.

Top module: `swb_exec_unit`

## Requirements
- R1: While reset is asserted, and at the first sample after it, the outputs read as follows: `wreg_q`=0, `flags_q`=0, `busy_q`=0, `rf_rd_en`=0, `rf_wr_en`=0 and `done_q`=0.
- R2: A word is accepted only if bits 15:10 equal 6'b010101. Any other word offered while the unit is idle is ignored: `busy_q` stays 0, W and the flags keep their values, and no write occurs.
- R3: After an accepting edge, the unit spends exactly four clocks busy, with `phase_q` at 0, 1, 2 and 3 in turn. `rf_rd_en` is high only in phase 1, and `rf_wr_en` is high only in phase 3.
- R4: The result is (W − operand − (1 − C)) mod 256.
- R5: With bit 9 = 0, the result goes to W and no register-file write takes place. With bit 9 = 1, the result is written at the instruction's address and W is unchanged.
- R6: With bit 8 = 1, the address is {bsr_in, bits 7:0}. With bit 8 = 0, `bsr_in` is ignored and the address is 0x000–0x07F for f below 0x80, or 0xF80–0xFFF otherwise.
- R7: The flags are laid out in `flags_q` as bit0 C, bit1 DC, bit2 Z, bit3 OV and bit4 N. C is 1 when the full subtraction needs no borrow. Z is 1 when the result is zero. N is result bit 7.
- R8: DC is 1 when the subtraction of the low nibbles, including the borrow, needs no borrow.
- R9: OV is 1 when W and the operand differ in sign and the result's sign differs from W's sign.
- R10: W and the flags change on the edge that ends phase 3. They still hold their old values during phase 3. `done_q` is high for the one clock after that edge.
- R11: The preloads `wreg_ld_en` and `flags_ld_en` take effect only while `busy_q` is 0. While busy they are ignored.
- R12: A word offered in phase 3 is accepted on the edge that ends it. The new instruction sees the W, flags and register contents left by the previous one, and completions follow each other every 4 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Instruction word offered |
| issue_word | input | 16 | Instruction word: opcode, destination bit, bank bit, file address |
| issue_ready | output | 1 | The unit can accept a word on this edge |
| bsr_in | input | 4 | Bank select value, captured at acceptance |
| wreg_ld_en | input | 1 | Preload W (idle only) |
| wreg_ld_data | input | 8 | Preload value for W |
| flags_ld_en | input | 1 | Preload flags (idle only) |
| flags_ld_data | input | 5 | Preload value for flags |
| rf_addr | output | 12 | Register-file address |
| rf_rd_en | output | 1 | Read strobe; data is expected one clock later |
| rf_rd_data | input | 8 | Read data from the register file |
| rf_wr_en | output | 1 | Write strobe |
| rf_wr_data | output | 8 | Write data |
| wreg_q | output | 8 | W register |
| flags_q | output | 5 | Flags {N, OV, Z, DC, C} |
| phase_q | output | 2 | Current phase (0–3) while busy |
| busy_q | output | 1 | An instruction is in progress |
| done_q | output | 1 | One-clock pulse after an instruction commits |

## Verification
The bench builds the unit with its default parameters: 8-bit data, an 8-bit file field and a 4-bit bank. With these values every addressing path is reachable: both halves of the access bank, and a banked address whose bank differs from both. Operand values near the sign and nibble boundaries bring each flag to both of its values. A pseudo-random stream of back-to-back instructions makes later instructions read registers and flags written by earlier ones, and this stream also exercises the one-per-four-clocks issue rate.

// File: rtl/swb_pkg.sv
package swb_pkg;
  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phase_e;

  localparam int FLG_C  = 0;
  localparam int FLG_DC = 1;
  localparam int FLG_Z  = 2;
  localparam int FLG_OV = 3;
  localparam int FLG_N  = 4;
  localparam int FLG_W  = 5;
endpackage

// File: rtl/swb_seq.sv
module swb_seq
  import swb_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   accept,
  output logic   busy_q,
  output phase_e phase_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      phase_q <= PH_Q1;
    end else if (accept) begin
      busy_q  <= 1'b1;
      phase_q <= PH_Q1;
    end else if (busy_q) begin
      if (phase_q == PH_Q4) busy_q <= 1'b0;
      phase_q <= phase_e'(phase_q + 2'd1);
    end
  end
endmodule

// File: rtl/swb_decode.sv
module swb_decode #(
  parameter int LO_W         = 8,
  parameter int BANK_W       = 4,
  parameter int ACCESS_SPLIT = 128
) (
  input  logic [LO_W+1:0]        field,
  input  logic [BANK_W-1:0]      bsr,
  output logic [BANK_W+LO_W-1:0] addr,
  output logic                   to_file
);
  localparam logic [LO_W-1:0]   SPLIT_V = LO_W'(ACCESS_SPLIT);
  localparam logic [BANK_W-1:0] TOP_BNK = '1;
  localparam logic [BANK_W-1:0] BOT_BNK = '0;

  logic [LO_W-1:0] f;
  logic            banked;

  always_comb begin
    f       = field[LO_W-1:0];
    banked  = field[LO_W];
    to_file = field[LO_W+1];
    if (banked)           addr = {bsr, f};
    else if (f < SPLIT_V) addr = {BOT_BNK, f};
    else                  addr = {TOP_BNK, f};
  end
endmodule

// File: rtl/swb_alu.sv
module swb_alu
  import swb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] opnd,
  input  logic              carry_in,
  output logic [DATA_W-1:0] diff,
  output logic [FLG_W-1:0]  flags
);
  localparam int NIB_W = DATA_W / 2;

  logic              borrow;
  logic [DATA_W:0]   full;
  logic [NIB_W:0]    low;

  always_comb begin
    borrow = ~carry_in;
    full   = {1'b0, acc} - {1'b0, opnd} - {{DATA_W{1'b0}}, borrow};
    low    = {1'b0, acc[NIB_W-1:0]} - {1'b0, opnd[NIB_W-1:0]}
             - {{NIB_W{1'b0}}, borrow};
    diff   = full[DATA_W-1:0];
    flags[FLG_C]  = ~full[DATA_W];
    flags[FLG_DC] = ~low[NIB_W];
    flags[FLG_Z]  = (full[DATA_W-1:0] == '0);
    flags[FLG_OV] = (acc[DATA_W-1] ^ opnd[DATA_W-1]) &
                    (full[DATA_W-1] ^ acc[DATA_W-1]);
    flags[FLG_N]  = full[DATA_W-1];
  end
endmodule

// File: rtl/swb_exec_unit.sv
module swb_exec_unit
  import swb_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int LO_W         = 8,
  parameter int BANK_W       = 4,
  parameter int ACCESS_SPLIT = 128,
  parameter int OPC_W        = 6,
  parameter logic [OPC_W-1:0] OPC_VAL = 6'b010101
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    issue_valid,
  input  logic [OPC_W+LO_W+1:0]   issue_word,
  output logic                    issue_ready,
  input  logic [BANK_W-1:0]       bsr_in,
  input  logic                    wreg_ld_en,
  input  logic [DATA_W-1:0]       wreg_ld_data,
  input  logic                    flags_ld_en,
  input  logic [4:0]              flags_ld_data,
  output logic [BANK_W+LO_W-1:0]  rf_addr,
  output logic                    rf_rd_en,
  input  logic [DATA_W-1:0]       rf_rd_data,
  output logic                    rf_wr_en,
  output logic [DATA_W-1:0]       rf_wr_data,
  output logic [DATA_W-1:0]       wreg_q,
  output logic [4:0]              flags_q,
  output logic [1:0]              phase_q,
  output logic                    busy_q,
  output logic                    done_q
);
  localparam int INSTR_W = OPC_W + LO_W + 2;
  localparam int ADDR_W  = BANK_W + LO_W;

  phase_e                 phase;
  logic                   busy;
  logic                   opc_hit;
  logic                   accept;
  logic [INSTR_W-1:0]     instr_q;
  logic [BANK_W-1:0]      bsr_q;
  logic [ADDR_W-1:0]      dec_addr;
  logic                   dec_to_file;
  logic [DATA_W-1:0]      alu_diff;
  logic [FLG_W-1:0]       alu_flags;
  logic [DATA_W-1:0]      res_q;
  logic [FLG_W-1:0]       flg_q;
  logic [ADDR_W-1:0]      addr_q;
  logic                   rd_q;
  logic                   wr_q;
  logic [DATA_W-1:0]      w_q;
  logic [FLG_W-1:0]       st_q;
  logic                   done_r;
  logic                   in_q1;
  logic                   in_q3;
  logic                   in_q4;

  assign opc_hit     = (issue_word[INSTR_W-1 -: OPC_W] == OPC_VAL);
  assign issue_ready = !busy || (phase == PH_Q4);
  assign accept      = issue_valid && issue_ready && opc_hit;
  assign in_q1       = busy && (phase == PH_Q1);
  assign in_q3       = busy && (phase == PH_Q3);
  assign in_q4       = busy && (phase == PH_Q4);

  swb_seq u_seq (
    .clk    (clk),
    .rst    (rst),
    .accept (accept),
    .busy_q (busy),
    .phase_q(phase)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      instr_q <= '0;
      bsr_q   <= '0;
    end else if (accept) begin
      instr_q <= issue_word;
      bsr_q   <= bsr_in;
    end
  end

  swb_decode #(
    .LO_W        (LO_W),
    .BANK_W      (BANK_W),
    .ACCESS_SPLIT(ACCESS_SPLIT)
  ) u_dec (
    .field  (instr_q[LO_W+1:0]),
    .bsr    (bsr_q),
    .addr   (dec_addr),
    .to_file(dec_to_file)
  );

  swb_alu #(.DATA_W(DATA_W)) u_alu (
    .acc     (w_q),
    .opnd    (rf_rd_data),
    .carry_in(st_q[FLG_C]),
    .diff    (alu_diff),
    .flags   (alu_flags)
  );

  // Q1 forms the address; Q2 holds the read strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      rd_q   <= 1'b0;
    end else begin
      rd_q <= in_q1;
      if (in_q1) addr_q <= dec_addr;
    end
  end

  // Q3 registers result and flags; Q4 drives the optional file write.
  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      flg_q <= '0;
      wr_q  <= 1'b0;
    end else if (in_q3) begin
      res_q <= alu_diff;
      flg_q <= alu_flags;
      wr_q  <= dec_to_file;
    end else begin
      wr_q  <= 1'b0;
    end
  end

  // Architectural state commits on the edge ending Q4.
  always_ff @(posedge clk) begin
    if (rst) begin
      w_q    <= '0;
      st_q   <= '0;
      done_r <= 1'b0;
    end else begin
      done_r <= in_q4;
      if (in_q4) begin
        st_q <= flg_q;
        if (!dec_to_file) w_q <= res_q;
      end else if (!busy) begin
        if (wreg_ld_en)  w_q  <= wreg_ld_data;
        if (flags_ld_en) st_q <= flags_ld_data;
      end
    end
  end

  assign rf_addr    = addr_q;
  assign rf_rd_en   = rd_q;
  assign rf_wr_en   = wr_q;
  assign rf_wr_data = res_q;
  assign wreg_q     = w_q;
  assign flags_q    = st_q;
  assign phase_q    = phase;
  assign busy_q     = busy;
  assign done_q     = done_r;
endmodule

// File: rtl/swb_exec_chk.sv
module swb_exec_chk #(
  parameter int DATA_W = 8,
  parameter int LO_W   = 8,
  parameter int BANK_W = 4,
  parameter int OPC_W  = 6,
  parameter logic [OPC_W-1:0] OPC_VAL = 6'b010101
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   issue_valid,
  input logic [OPC_W+LO_W+1:0]  issue_word,
  input logic                   wreg_ld_en,
  input logic [BANK_W+LO_W-1:0] rf_addr,
  input logic                   rf_rd_en,
  input logic                   rf_wr_en,
  input logic [DATA_W-1:0]      wreg_q,
  input logic [1:0]             phase_q,
  input logic                   busy_q,
  input logic                   done_q
);
  localparam int INSTR_W = OPC_W + LO_W + 2;

  a_r3_read_in_q2: assert property (@(posedge clk) disable iff (rst)
    rf_rd_en |-> (busy_q && phase_q == 2'd1));

  a_r3_write_in_q4: assert property (@(posedge clk) disable iff (rst)
    rf_wr_en |-> (busy_q && phase_q == 2'd3));

  a_r3_phase_step: assert property (@(posedge clk) disable iff (rst)
    (busy_q && phase_q != 2'd3) |=> (busy_q && phase_q == $past(phase_q) + 2'd1));

  a_r10_done_after_q4: assert property (@(posedge clk) disable iff (rst)
    done_q |-> ($past(busy_q) && $past(phase_q) == 2'd3));

  a_r5_file_dest_keeps_w: assert property (@(posedge clk) disable iff (rst)
    rf_wr_en |=> (wreg_q == $past(wreg_q)));

  a_r11_idle_w_holds: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && !wreg_ld_en) |=> (wreg_q == $past(wreg_q)));

  a_r2_bad_opcode_idle: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && issue_valid && issue_word[INSTR_W-1 -: OPC_W] != OPC_VAL) |=> !busy_q);

  a_r6_addr_held: assert property (@(posedge clk) disable iff (rst)
    (busy_q && phase_q[1]) |-> $stable(rf_addr));
endmodule

bind swb_exec_unit swb_exec_chk #(
  .DATA_W (DATA_W),
  .LO_W   (LO_W),
  .BANK_W (BANK_W),
  .OPC_W  (OPC_W),
  .OPC_VAL(OPC_VAL)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .issue_valid(issue_valid),
  .issue_word (issue_word),
  .wreg_ld_en (wreg_ld_en),
  .rf_addr    (rf_addr),
  .rf_rd_en   (rf_rd_en),
  .rf_wr_en   (rf_wr_en),
  .wreg_q     (wreg_q),
  .phase_q    (phase_q),
  .busy_q     (busy_q),
  .done_q     (done_q)
);

// File: tb/test_swb_exec_unit.sv
module test_swb_exec_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_valid = 1'b0;
  logic [15:0] issue_word = '0;
  logic        issue_ready;
  logic [3:0]  bsr_in = '0;
  logic        wreg_ld_en = 1'b0;
  logic [7:0]  wreg_ld_data = '0;
  logic        flags_ld_en = 1'b0;
  logic [4:0]  flags_ld_data = '0;
  logic [11:0] rf_addr;
  logic        rf_rd_en;
  logic [7:0]  rf_rd_data = '0;
  logic        rf_wr_en;
  logic [7:0]  rf_wr_data;
  logic [7:0]  wreg_q;
  logic [4:0]  flags_q;
  logic [1:0]  phase_q;
  logic        busy_q;
  logic        done_q;

  always #2 clk = ~clk;

  swb_exec_unit i_swb_exec_unit (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_word(issue_word),
    .issue_ready(issue_ready), .bsr_in(bsr_in), .wreg_ld_en(wreg_ld_en),
    .wreg_ld_data(wreg_ld_data), .flags_ld_en(flags_ld_en),
    .flags_ld_data(flags_ld_data), .rf_addr(rf_addr), .rf_rd_en(rf_rd_en),
    .rf_rd_data(rf_rd_data), .rf_wr_en(rf_wr_en), .rf_wr_data(rf_wr_data),
    .wreg_q(wreg_q), .flags_q(flags_q), .phase_q(phase_q), .busy_q(busy_q),
    .done_q(done_q)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int first_done = -1;
  int last_done  = -1;
  int done_seen  = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Register-file model with one clock of read latency.
  logic [7:0]  ram [int];
  logic        poke_en = 1'b0;
  logic [11:0] poke_addr = '0;
  logic [7:0]  poke_data = '0;

  always @(posedge clk) begin
    logic [7:0] rv;
    rv = ram.exists(int'(rf_addr)) ? ram[int'(rf_addr)] : 8'h00;
    if (rf_rd_en) rf_rd_data <= rv;
    if (rf_wr_en) ram[int'(rf_addr)] = rf_wr_data;
    else if (poke_en) ram[int'(poke_addr)] = poke_data;
  end

  typedef struct {
    bit         to_file;
    logic [11:0] addr;
    logic [7:0]  res;
    logic [7:0]  w;
    logic [4:0]  fl;
  } exp_t;

  exp_t       sbq[$];
  logic [7:0] m_w  = '0;
  logic [4:0] m_fl = '0;
  logic [7:0] m_mem [int];

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Reference model written from the requirements.
  task automatic model_exec(input logic [15:0] word, input logic [3:0] bsr);
    exp_t e;
    logic [7:0] f, op, res;
    logic       b, c, dc, ov;
    logic [8:0] full;
    logic [4:0] lo;
    f = word[7:0];
    if (word[8])        e.addr = {bsr, f};        // R6 banked
    else if (f < 8'h80) e.addr = {4'h0, f};       // R6 access low
    else                e.addr = {4'hF, f};       // R6 access high
    op   = m_mem.exists(int'(e.addr)) ? m_mem[int'(e.addr)] : 8'h00;
    b    = ~m_fl[0];
    full = {1'b0, m_w} - {1'b0, op} - {8'h00, b};
    lo   = {1'b0, m_w[3:0]} - {1'b0, op[3:0]} - {4'h0, b};
    res  = full[7:0];
    c    = (m_w >= op) && !((m_w == op) && b);
    dc   = ~lo[4];
    ov   = (m_w[7] != op[7]) && (res[7] != m_w[7]);
    m_fl = {res[7], ov, (res == 8'h00), dc, c};
    e.to_file = word[9];
    e.res     = res;
    if (word[9]) m_mem[int'(e.addr)] = res;
    else         m_w = res;
    e.w  = m_w;
    e.fl = m_fl;
    sbq.push_back(e);
  endtask

  // Monitor: compare committed results with the queue.
  bit saw_wr = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (rf_wr_en) begin
        if (sbq.size() == 0) chk("R5", "unexpected write", 32'd1, 32'd0);
        else begin
          chk("R6", "write address", 32'(rf_addr), 32'(sbq[0].addr));
          chk("R4", "write data", 32'(rf_wr_data), 32'(sbq[0].res));
        end
        saw_wr = 1'b1;
      end
      if (done_q) begin
        if (done_seen == 0) first_done = cyc;
        last_done = cyc;
        done_seen++;
        if (sbq.size() == 0) chk("R2", "unexpected completion", 32'd1, 32'd0);
        else begin
          exp_t e;
          e = sbq.pop_front();
          chk("R5", "file write seen", 32'(saw_wr), 32'(e.to_file));
          chk("R4", "W after commit", 32'(wreg_q), 32'(e.w));
          chk("R7", "flags after commit", 32'(flags_q), 32'(e.fl));
        end
        saw_wr = 1'b0;
      end
    end
  end

  task automatic issue(input logic [15:0] word, input logic [3:0] bsr);
    @(negedge clk);
    while (!issue_ready) @(negedge clk);
    issue_valid = 1'b1;
    issue_word  = word;
    bsr_in      = bsr;
    model_exec(word, bsr);
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (busy_q || sbq.size() != 0) @(negedge clk);
  endtask

  task automatic set_w(input logic [7:0] v);
    @(negedge clk);
    wreg_ld_en = 1'b1; wreg_ld_data = v; m_w = v;
    @(negedge clk);
    wreg_ld_en = 1'b0;
  endtask

  task automatic set_fl(input logic [4:0] v);
    @(negedge clk);
    flags_ld_en = 1'b1; flags_ld_data = v; m_fl = v;
    @(negedge clk);
    flags_ld_en = 1'b0;
  endtask

  task automatic poke(input logic [11:0] a, input logic [7:0] v);
    @(negedge clk);
    poke_en = 1'b1; poke_addr = a; poke_data = v;
    m_mem[int'(a)] = v;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  function automatic logic [15:0] mk(input bit d, input bit a, input logic [7:0] f);
    return {6'b010101, d, a, f};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [15:0] lfsr;
    logic [7:0]  w_before;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "W", 32'(wreg_q), 32'h0);
    chk("R1", "flags", 32'(flags_q), 32'h0);
    chk("R1", "busy", 32'(busy_q), 32'h0);
    chk("R1", "strobes", 32'({rf_rd_en, rf_wr_en, done_q}), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "busy after release", 32'(busy_q), 32'h0);

    // R3 / R10: phase walk of one file-destination instruction (W=2,f=3,C=1)
    set_w(8'h02); set_fl(5'h01); poke(12'h020, 8'h03);
    issue(mk(1'b1, 1'b0, 8'h20), 4'h0);
    chk("R3", "phase 0", 32'({busy_q, phase_q, rf_rd_en, rf_wr_en}), 32'({1'b1, 2'd0, 2'b00}));
    @(negedge clk);
    chk("R3", "phase 1", 32'({busy_q, phase_q, rf_rd_en, rf_wr_en}), 32'({1'b1, 2'd1, 2'b10}));
    @(negedge clk);
    chk("R3", "phase 2", 32'({busy_q, phase_q, rf_rd_en, rf_wr_en}), 32'({1'b1, 2'd2, 2'b00}));
    @(negedge clk);
    chk("R3", "phase 3", 32'({busy_q, phase_q, rf_rd_en, rf_wr_en}), 32'({1'b1, 2'd3, 2'b01}));
    chk("R10", "flags still old in phase 3", 32'(flags_q), 32'h01);
    @(negedge clk);
    chk("R10", "done after commit", 32'({done_q, busy_q}), 32'b10);
    chk("R7", "0xFF result flags N", 32'(flags_q), 32'h10);
    chk("R5", "W unchanged on file dest", 32'(wreg_q), 32'h02);

    // R4 / R7 worked values
    set_w(8'h05); set_fl(5'h01); poke(12'h021, 8'h02);
    issue(mk(1'b0, 1'b0, 8'h21), 4'h0); drain();
    chk("R4", "5-2", 32'(wreg_q), 32'h03);
    chk("R7", "5-2 flags", 32'(flags_q), 32'h03);
    set_w(8'h02); set_fl(5'h00); poke(12'h022, 8'h01);
    issue(mk(1'b1, 1'b0, 8'h22), 4'h0); drain();
    chk("R7", "zero result flags", 32'(flags_q), 32'h07);

    // R6 addressing
    poke(12'h090, 8'h11); poke(12'hF90, 8'h22); poke(12'h590, 8'h33);
    poke(12'h010, 8'h05); poke(12'h510, 8'h50);
    set_w(8'h80); set_fl(5'h01);
    issue(mk(1'b0, 1'b0, 8'h90), 4'h5); drain();
    chk("R6", "access high bank", 32'(wreg_q), 32'h5E);
    set_w(8'h80); set_fl(5'h01);
    issue(mk(1'b0, 1'b1, 8'h90), 4'h5); drain();
    chk("R6", "banked", 32'(wreg_q), 32'h4D);
    set_w(8'h80); set_fl(5'h01);
    issue(mk(1'b0, 1'b0, 8'h10), 4'h5); drain();
    chk("R6", "access low ignores bank", 32'(wreg_q), 32'h7B);

    // R8 nibble borrow, R9 overflow
    poke(12'h030, 8'h01); poke(12'h031, 8'hFF);
    set_w(8'h10); set_fl(5'h01);
    issue(mk(1'b0, 1'b0, 8'h30), 4'h0); drain();
    chk("R8", "DC cleared", 32'(flags_q), 32'h01);
    set_w(8'h80); set_fl(5'h01);
    issue(mk(1'b0, 1'b0, 8'h30), 4'h0); drain();
    chk("R9", "OV 0x80-1", 32'(flags_q), 32'h09);
    set_w(8'h7F); set_fl(5'h01);
    issue(mk(1'b0, 1'b0, 8'h31), 4'h0); drain();
    chk("R9", "OV 0x7F-0xFF", 32'(flags_q), 32'h1A);

    // R2 non-matching opcode
    w_before = wreg_q;
    @(negedge clk);
    issue_valid = 1'b1; issue_word = 16'h5030;
    @(negedge clk);
    issue_valid = 1'b0;
    chk("R2", "not busy", 32'(busy_q), 32'h0);
    repeat (6) @(negedge clk);
    chk("R2", "W unchanged", 32'(wreg_q), 32'(w_before));

    // R11 preload ignored while busy
    set_w(8'h30); set_fl(5'h01); poke(12'h040, 8'h10);
    issue(mk(1'b0, 1'b0, 8'h40), 4'h0);
    wreg_ld_en = 1'b1; wreg_ld_data = 8'hAA;
    flags_ld_en = 1'b1; flags_ld_data = 5'h1F;
    @(negedge clk);
    wreg_ld_en = 1'b0; flags_ld_en = 1'b0;
    drain();
    chk("R11", "W ignores busy preload", 32'(wreg_q), 32'h20);
    chk("R11", "flags ignore busy preload", 32'(flags_q), 32'h03);

    // R12 back-to-back pseudo-random stream over a few registers
    lfsr = 16'hACE1;
    done_seen = 0;
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      issue(mk(lfsr[0], lfsr[1], {lfsr[2], 4'h0, lfsr[5:3]}), {2'b00, lfsr[7:6]});
    end
    drain();
    chk("R12", "completions", 32'(done_seen), 32'd40);
    chk("R12", "issue spacing", 32'(last_done - first_done), 32'd156);

    report();
  end
endmodule